// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block is the bus-side timing machine of a small embedded processor. It runs on its own, apart from the instruction execution sequencer. It takes a transfer request from the core and decides whether the shared bus may be used. The bus counts as usable only when the arbiter grants it, no other master has it busy, and nobody holds a lock on it.

A transfer takes at least two phases. The address phase lasts until the slave signals address-ready. The data phase lasts until the slave signals data-ready. A wait state covers the time in which a request is pending but the bus cannot be used. When the data phase ends, the machine does one of three things. It starts a new address phase at once if another request is pending and the bus is usable. It parks in the wait state if a request is pending but the bus is not usable. Otherwise it goes back to idle.

The outputs are decodes of the phase state: an address-valid strobe, a data strobe and a cycle-done pulse. A bus-wait level tells the execution side to stall.

Top module: `bus_cycle_seq`

## Requirements
- R1: The reset `rst_n` is synchronous and active low. At a clock edge that samples it low, the machine enters idle, so that from the next cycle `addr_valid` and `data_strobe` are 0.
- R2: `bus_avail` is 1 exactly when `bus_grant` is 1, `bus_busy` is 0 and `bus_lock` is 0, in the same cycle.
- R3: From idle, the machine moves as follows at a clock edge. With `bus_req` high and the bus available, it enters the address phase. With `bus_req` high and the bus unavailable, it enters the wait state. With `bus_req` low, it stays idle. The state is always exactly one of idle, wait, address or data.
- R4: In the wait state the machine stays while the bus is unavailable. It enters the address phase at the first edge where the bus is available, whatever `bus_req` is.
- R5: `addr_valid` is high exactly while the machine is in the address phase. The phase holds while `addr_rdy` is low and moves to the data phase at an edge where `addr_rdy` is high.
- R6: `data_strobe` is high exactly while the machine is in the data phase. The phase holds while `data_rdy` is low.
- R7: At an edge in the data phase with `data_rdy` high, the next state depends on the inputs. It is the address phase if `bus_req` is high and the bus is available. It is the wait state if `bus_req` is high and the bus is unavailable. It is idle if `bus_req` is low.
- R8: `cycle_done` is high exactly in a cycle that is in the data phase with `data_rdy` high. It is never high in two consecutive cycles.
- R9: `bus_wait` is high when the machine is outside idle, or when `bus_req` is high, except in a cycle where `cycle_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_req | input | 1 | Transfer request from the core |
| bus_grant | input | 1 | Arbiter grant |
| bus_busy | input | 1 | Bus occupied by another master |
| bus_lock | input | 1 | Bus locked |
| addr_rdy | input | 1 | Slave accepted the address |
| data_rdy | input | 1 | Slave completed the data transfer |
| bus_avail | output | 1 | Bus usable this cycle |
| addr_valid | output | 1 | Address phase strobe |
| data_strobe | output | 1 | Data phase strobe |
| cycle_done | output | 1 | Transfer completes this cycle |
| bus_wait | output | 1 | Stall indication to the execution side |

## Verification
On every clock cycle, the in-line assertions check the following: each single transition rule from idle, wait, address and data; that the state stays one-hot; that `cycle_done` never lasts two cycles; and that a completing cycle drops `bus_wait`. Only the bench scenarios can show the rest. These are the combined effect of reset in the middle of a transfer, long chains of transfers back to back with the bus taken away between them, and long phases stretched by the ready handshakes. For these, the scenarios compare every output in every cycle against a reference model built from the requirements.

// File: rtl/bus_seq_pkg.sv
// Package: shared state encoding for the external bus cycle sequencer.
// Assumes one-hot state vectors; the index constants fix bit positions.
package bus_seq_pkg;
    localparam int N_STATES = 4;
    localparam int IDX_IDLE = 0;
    localparam int IDX_WAIT = 1;
    localparam int IDX_ADDR = 2;
    localparam int IDX_DATA = 3;

    typedef logic [N_STATES-1:0] seq_state_t;

    localparam seq_state_t ST_IDLE = seq_state_t'(1) << IDX_IDLE;
    localparam seq_state_t ST_WAIT = seq_state_t'(1) << IDX_WAIT;
    localparam seq_state_t ST_ADDR = seq_state_t'(1) << IDX_ADDR;
    localparam seq_state_t ST_DATA = seq_state_t'(1) << IDX_DATA;
endpackage

// File: rtl/bus_avail_qual.sv
// Module: bus_avail_qual
// Combines the three arbitration inputs into one "bus usable" term.
// Assumes all inputs are synchronous to the sequencer clock.
module bus_avail_qual (
    input  logic grant,
    input  logic busy,
    input  logic lock,
    output logic avail
);
    // Bus usable only when granted, not busy and not locked.
    always_comb begin
        avail = grant & ~busy & ~lock;
    end
endmodule

// File: rtl/bus_seq_fsm.sv
// Module: bus_seq_fsm
// One-hot state register and next-state logic for idle, wait-for-bus,
// address phase and data phase. Any illegal state vector falls back
// to idle. Assumes a synchronous active-low reset held for at least one edge.
module bus_seq_fsm
    import bus_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       avail,
    input  logic       addr_rdy,
    input  logic       data_rdy,
    output seq_state_t state
);
    seq_state_t state_nxt;

    // Pick the state that follows when one transfer ends.
    function automatic seq_state_t after_request(input logic rq, input logic av);
        if (!rq)      return ST_IDLE;
        else if (av)  return ST_ADDR;
        else          return ST_WAIT;
    endfunction

    // Next-state decode, with recovery to idle from illegal vectors.
    always_comb begin
        state_nxt = ST_IDLE;
        case (state)
            ST_IDLE: state_nxt = after_request(req, avail);
            ST_WAIT: state_nxt = avail ? ST_ADDR : ST_WAIT;
            ST_ADDR: state_nxt = addr_rdy ? ST_DATA : ST_ADDR;
            ST_DATA: state_nxt = data_rdy ? after_request(req, avail) : ST_DATA;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // R3
    state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state) == 1);
    // R3
    idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req && avail) |=> state == ST_ADDR);
    // R3
    idle_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req && !avail) |=> state == ST_WAIT);
    // R3
    idle_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !req) |=> state == ST_IDLE);
    // R4
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !avail) |=> state == ST_WAIT);
    // R4
    wait_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && avail) |=> state == ST_ADDR);
    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && !addr_rdy) |=> state == ST_ADDR);
    // R5
    addr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && addr_rdy) |=> state == ST_DATA);
    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !data_rdy) |=> state == ST_DATA);
    // R7
    data_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && data_rdy && req && avail) |=> state == ST_ADDR);
    // R7
    data_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && data_rdy && req && !avail) |=> state == ST_WAIT);
    // R7
    data_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && data_rdy && !req) |=> state == ST_IDLE);
endmodule

// File: rtl/bus_seq_decode.sv
// Module: bus_seq_decode
// Turns the one-hot state into phase strobes, the completion pulse and
// the stall level for the execution side. Purely combinational.
module bus_seq_decode
    import bus_seq_pkg::*;
(
    input  seq_state_t state,
    input  logic       req,
    input  logic       data_rdy,
    output logic       addr_valid,
    output logic       data_strobe,
    output logic       cycle_done,
    output logic       bus_wait
);
    // Phase strobes and completion straight from the state bits.
    always_comb begin
        addr_valid  = state[IDX_ADDR];
        data_strobe = state[IDX_DATA];
        cycle_done  = state[IDX_DATA] & data_rdy;
    end

    // Stall while a transfer is outstanding and not finishing now.
    always_comb begin
        bus_wait = (~state[IDX_IDLE] | req) & ~(state[IDX_DATA] & data_rdy);
    end
endmodule

// File: rtl/bus_cycle_seq.sv
// Module: bus_cycle_seq (top)
// External bus cycle sequencer: availability qualifier, phase state
// machine and output decode. Assumes all inputs are synchronous to clk.
module bus_cycle_seq
    import bus_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_req,
    input  logic bus_grant,
    input  logic bus_busy,
    input  logic bus_lock,
    input  logic addr_rdy,
    input  logic data_rdy,
    output logic bus_avail,
    output logic addr_valid,
    output logic data_strobe,
    output logic cycle_done,
    output logic bus_wait
);
    seq_state_t state;

    bus_avail_qual u_qual (
        .grant (bus_grant),
        .busy  (bus_busy),
        .lock  (bus_lock),
        .avail (bus_avail)
    );

    bus_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (bus_req),
        .avail    (bus_avail),
        .addr_rdy (addr_rdy),
        .data_rdy (data_rdy),
        .state    (state)
    );

    bus_seq_decode u_dec (
        .state       (state),
        .req         (bus_req),
        .data_rdy    (data_rdy),
        .addr_valid  (addr_valid),
        .data_strobe (data_strobe),
        .cycle_done  (cycle_done),
        .bus_wait    (bus_wait)
    );

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done);
    // R9
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> !bus_wait);
    // R5
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_valid && data_strobe));
endmodule

// File: tb/tb_bus_cycle_seq.sv
module tb_bus_cycle_seq;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_req = 1'b0, bus_grant = 1'b0, bus_busy = 1'b0, bus_lock = 1'b0;
    logic addr_rdy = 1'b0, data_rdy = 1'b0;
    logic bus_avail, addr_valid, data_strobe, cycle_done, bus_wait;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cycle_seq dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_grant(bus_grant),
        .bus_busy(bus_busy), .bus_lock(bus_lock), .addr_rdy(addr_rdy),
        .data_rdy(data_rdy), .bus_avail(bus_avail), .addr_valid(addr_valid),
        .data_strobe(data_strobe), .cycle_done(cycle_done), .bus_wait(bus_wait)
    );

    typedef enum logic [1:0] {M_IDLE, M_WAIT, M_ADDR, M_DATA} mst_e;
    typedef struct {
        logic  av, adv, ds, dn, wt;
        string tag;
    } exp_t;

    exp_t  q[$];
    mst_e  m_st  = M_IDLE;
    string m_tag = "R1";
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;

    // Driver: apply inputs, push expectation, advance reference model.
    task automatic step(input bit rn, rq, g, bz, lk, ar, dr);
        exp_t e;
        logic avl;
        mst_e nx;
        string tg;
        @(negedge clk);
        rst_n = rn; bus_req = rq; bus_grant = g; bus_busy = bz;
        bus_lock = lk; addr_rdy = ar; data_rdy = dr;
        #1;
        avl   = g & ~bz & ~lk;
        e.av  = avl;
        e.adv = (m_st == M_ADDR);
        e.ds  = (m_st == M_DATA);
        e.dn  = (m_st == M_DATA) && dr;
        e.wt  = ((m_st != M_IDLE) || rq) && !e.dn;
        e.tag = m_tag;
        q.push_back(e);
        nx = m_st; tg = "R3";
        if (!rn) begin nx = M_IDLE; tg = "R1"; end
        else case (m_st)
            M_IDLE: begin nx = !rq ? M_IDLE : (avl ? M_ADDR : M_WAIT); tg = "R3"; end
            M_WAIT: begin nx = avl ? M_ADDR : M_WAIT; tg = "R4"; end
            M_ADDR: begin nx = ar ? M_DATA : M_ADDR; tg = "R5"; end
            M_DATA: begin
                if (dr) begin nx = !rq ? M_IDLE : (avl ? M_ADDR : M_WAIT); tg = "R7"; end
                else    begin nx = M_DATA; tg = "R6"; end
            end
            default: begin nx = M_IDLE; tg = "R1"; end
        endcase
        m_st = nx; m_tag = tg;
    endtask

    task automatic chk(input string req_tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req_tag, what, act, exp, $time);
        end
    endtask

    // Monitor: pop each expectation and compare with the outputs.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk("R2", "bus_avail", bus_avail, e.av);
                chk({"R5/", e.tag}, "addr_valid", addr_valid, e.adv);
                chk({"R6/", e.tag}, "data_strobe", data_strobe, e.ds);
                chk("R8", "cycle_done", cycle_done, e.dn);
                chk("R9", "bus_wait", bus_wait, e.wt);
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset held for two edges; model starts in idle.
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        step(0, 1, 1, 0, 0, 1, 1);             // R1 outputs idle while in reset
        step(1, 0, 1, 0, 0, 0, 0);             // R3 stay idle, no request
        // R3/R5/R6/R7: simple transfer with stretched phases.
        step(1, 1, 1, 0, 0, 0, 0);
        step(1, 1, 1, 0, 0, 0, 0);             // R5 addr hold
        step(1, 1, 1, 0, 0, 1, 0);
        step(1, 1, 1, 0, 0, 0, 0);             // R6 data hold
        step(1, 0, 1, 0, 0, 0, 1);             // R7 end to idle
        // R2/R4: blocked by lock, busy, no grant, then released.
        step(1, 1, 1, 0, 1, 0, 0);
        step(1, 1, 1, 1, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);             // R4 waits regardless of request
        step(1, 0, 1, 0, 0, 0, 0);             // R4 go when available
        step(1, 1, 1, 0, 0, 1, 0);
        // R7: chain back to back, then park in wait.
        step(1, 1, 1, 0, 0, 0, 1);
        step(1, 1, 1, 0, 0, 1, 0);
        step(1, 1, 1, 1, 0, 0, 1);             // R7 park in wait
        step(1, 1, 1, 0, 0, 1, 0);
        step(1, 1, 1, 0, 0, 1, 0);
        // R1: reset in the middle of the data phase.
        step(0, 1, 1, 0, 0, 0, 0);
        step(1, 0, 1, 0, 0, 0, 0);
        // Randomised traffic against the model.
        for (int i = 0; i < 4000; i++) begin
            step(($urandom_range(0, 199) != 0),
                 ($urandom_range(0, 3) != 0),
                 ($urandom_range(0, 4) != 0),
                 ($urandom_range(0, 5) == 0),
                 ($urandom_range(0, 7) == 0),
                 ($urandom_range(0, 1) == 0),
                 ($urandom_range(0, 2) == 0));
        end
        repeat (3) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule